// File: doc/BRIEF.md
# Block-Transfer Mailbox Host Register Interface

This block is the host-facing side of a byte-wide block-transfer mailbox between a host processor and a management controller. The host sees three byte registers behind a two-bit address: a control register holding the attention and busy flags, a data port that fills a request buffer on writes and drains a response buffer on reads, and an interrupt mask register holding an enable bit and a pending bit. The block drives one level-sensitive interrupt toward the host.

The controller side reads the request bytes by index and receives a one-cycle request-ready pulse when the host rings the request doorbell. It writes response bytes by index and then commits a response length, which hands the response to the host, drops the controller busy flag and raises controller-to-host attention. A separate set/clear input, with an optional interrupt-request qualifier, drives the system-attention flag. The request length counter keeps counting past the buffer depth and saturates, so a host overrun stays visible to the controller.

Top module: `bt_host_regs`

## Requirements
- R1: Reads decode the low address bits as 0 = control, 1 = data, 2 = mask; a read at address 3 returns 0xFF. The control byte reads as bit7 controller busy, bit6 host busy, bit4 system attention, bit3 controller-to-host attention, all other bits 0; the mask byte reads as bit1 pending, bit0 enable, other bits 0.
- R2: On a control write, a 1 in bit3 clears controller-to-host attention, a 1 in bit4 clears system attention, and a 1 in bit6 toggles host busy; 0 bits leave those flags unchanged.
- R3: A control write with bit2 set makes controller busy 1 after that edge and drives `req_ready` high for exactly the following cycle.
- R4: A data write stores the byte at index `req_len` only while `req_len` is below the depth; `req_len` increases by one on every data write (saturating at its all-ones value), and bytes written past the depth do not disturb stored bytes.
- R5: A data read returns the next committed response byte and advances; after the last byte both position and length return to zero. With nothing pending a data read returns 0xFF.
- R6: A control write with bit0 set returns `req_len` to 0; with bit1 set it returns the response read position to the first byte.
- R7: A mask write that changes enable from 0 to 1 sets pending when either attention flag is set; a change from 1 to 0 clears pending and enable.
- R8: A mask write with bit1 set clears pending when it is set.
- R9: Setting system attention with `sms_irq` high sets pending only when controller-to-host attention is clear and enable is set; clearing system attention drops pending only when controller-to-host attention is clear.
- R10: A response commit clears controller busy, sets controller-to-host attention and, when enabled, sets pending.
- R11: `irq_out` is high only while pending is set and `irq_glb_en` is high; pending still sets while `irq_glb_en` is low.
- R12: After reset all flags, enable, pending, `req_len` and the response length are 0 and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous cold reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid in the strobe cycle |
| irq_glb_en | input | 1 | Global gate for the interrupt output |
| irq_out | output | 1 | Level interrupt to the host |
| req_ready | output | 1 | One-cycle request doorbell pulse |
| req_len | output | LEN_W | Request byte count, saturating |
| req_rd_idx | input | IDX_W | Controller request read index |
| req_rd_data | output | 8 | Request byte at that index |
| rsp_wr_en | input | 1 | Controller response byte write |
| rsp_wr_idx | input | IDX_W | Response byte index |
| rsp_wr_data | input | 8 | Response byte |
| rsp_commit | input | 1 | Hand the response to the host |
| rsp_commit_len | input | LEN_W | Committed response length, clamped to depth |
| sms_set | input | 1 | Set system attention |
| sms_clr | input | 1 | Clear system attention |
| sms_irq | input | 1 | Qualifies a set as interrupt-raising |

## Verification
Read data is combinational, so every register read is compared in the same cycle its strobe is high, at the falling edge. Flag, mask, length and pending updates land on the rising edge that ends the strobe, and `irq_out` follows pending combinationally, so the bench checks them at the falling edge right after that write. The doorbell pulse is registered: it is checked high at the first falling edge after the control write and low at the next.

// File: rtl/bt_pkg.sv
package bt_pkg;

  // control register bit positions (host software decodes these)
  localparam int CB_WPTR_CLR = 0;
  localparam int CB_RPTR_CLR = 1;
  localparam int CB_REQ_GO   = 2;
  localparam int CB_RSP_ATN  = 3;
  localparam int CB_SYS_ATN  = 4;
  localparam int CB_HOST_BSY = 6;
  localparam int CB_CTL_BSY  = 7;
  // mask register bit positions
  localparam int MB_EN   = 0;
  localparam int MB_PEND = 1;

  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_DAT = 2'd1;
  localparam logic [1:0] A_MSK = 2'd2;

  typedef struct packed {
    logic rsp_atn;
    logic sys_atn;
    logic host_bsy;
    logic ctl_bsy;
    logic en;
    logic pend;
  } bt_flags_t;

  function automatic logic [7:0] ctl_byte(bt_flags_t f);
    logic [7:0] b;
    b = 8'h00;
    b[CB_CTL_BSY]  = f.ctl_bsy;
    b[CB_HOST_BSY] = f.host_bsy;
    b[CB_SYS_ATN]  = f.sys_atn;
    b[CB_RSP_ATN]  = f.rsp_atn;
    return b;
  endfunction

  function automatic logic [7:0] msk_byte(bt_flags_t f);
    logic [7:0] b;
    b = 8'h00;
    b[MB_PEND] = f.pend;
    b[MB_EN]   = f.en;
    return b;
  endfunction

  // Same-cycle events apply in a fixed order: host control write, host mask
  // write, response commit, then system-attention change.
  function automatic bt_flags_t flags_next(bt_flags_t cur, logic ctl_wr,
      logic msk_wr, logic [7:0] wd, logic commit, logic s_set,
      logic s_clr, logic s_irq);
    bt_flags_t n;
    n = cur;
    if (ctl_wr) begin
      if (wd[CB_RSP_ATN])  n.rsp_atn  = 1'b0;
      if (wd[CB_SYS_ATN])  n.sys_atn  = 1'b0;
      if (wd[CB_HOST_BSY]) n.host_bsy = ~cur.host_bsy;
      if (wd[CB_REQ_GO])   n.ctl_bsy  = 1'b1;
    end
    if (msk_wr) begin
      if (wd[MB_EN] != cur.en) begin
        if (wd[MB_EN]) begin
          if (n.rsp_atn || n.sys_atn) n.pend = 1'b1;
          n.en = 1'b1;
        end else begin
          n.pend = 1'b0;
          n.en   = 1'b0;
        end
      end
      if (wd[MB_PEND] && cur.pend) n.pend = 1'b0;
    end
    if (commit) begin
      n.ctl_bsy = 1'b0;
      n.rsp_atn = 1'b1;
      if (!n.pend && n.en) n.pend = 1'b1;
    end
    if (s_set && !n.sys_atn) begin
      n.sys_atn = 1'b1;
      if (s_irq && !n.rsp_atn && n.en) n.pend = 1'b1;
    end else if (s_clr && n.sys_atn) begin
      n.sys_atn = 1'b0;
      if (!n.rsp_atn && n.pend) n.pend = 1'b0;
    end
    return n;
  endfunction

  // response length as stored: never longer than the buffer
  function automatic int unsigned clamp_len(int unsigned req, int unsigned depth);
    return (req > depth) ? depth : req;
  endfunction

endpackage

// File: rtl/bt_flag_ctl.sv
module bt_flag_ctl
  import bt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ctl_wr,
  input  logic      msk_wr,
  input  logic [7:0] wdata,
  input  logic      rsp_commit,
  input  logic      sms_set,
  input  logic      sms_clr,
  input  logic      sms_irq,
  output bt_flags_t flags
);

  bt_flags_t flags_d;
  logic      pend_src;   // any event allowed to raise pending

  assign pend_src = msk_wr | rsp_commit | sms_set;

  always_comb begin
    flags_d = flags_next(flags, ctl_wr, msk_wr, wdata, rsp_commit,
                         sms_set, sms_clr, sms_irq);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

  // R7: pending only rises from an enable change, a commit or an attention set
  a_r7_pend_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags.pend) |-> $past(pend_src));

  // R8: pending never stands without enable
  a_r8_pend_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    flags.pend |-> flags.en);

  // R10: commit hands the response over
  a_r10_commit_flags: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_commit |=> (flags.rsp_atn && !flags.ctl_bsy));

endmodule

// File: rtl/bt_req_buf.sv
module bt_req_buf #(
  parameter int DEPTH = 64,
  parameter int LEN_W = $clog2(DEPTH + 1) + 1,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             clr,
  input  logic [7:0]       wdata,
  output logic [LEN_W-1:0] len,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);

  localparam logic [LEN_W-1:0] LEN_MAX = '1;
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(DEPTH);

  logic [7:0] mem [DEPTH];
  logic       store;

  assign store = wr_en && (len < LEN_CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          len <= '0;
    else if (clr)                        len <= '0;
    else if (wr_en && len != LEN_MAX)    len <= len + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (store) mem[len[IDX_W-1:0]] <= wdata;
  end

  assign rd_data = mem[rd_idx];

  // R4: each data write advances the count by one until saturation
  a_r4_len_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && len != LEN_MAX) |=> (len == $past(len) + 1'b1));

endmodule

// File: rtl/bt_rsp_buf.sv
module bt_rsp_buf
  import bt_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = $clog2(DEPTH + 1) + 1,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic             commit,
  input  logic [LEN_W-1:0] commit_len,
  input  logic             rd_en,
  input  logic             pos_clr,
  output logic [7:0]       rd_data
);

  logic [7:0]       mem [DEPTH];
  logic [LEN_W-1:0] pos, len, len_cl;
  logic             avail, last;

  assign len_cl = LEN_W'(clamp_len(int'(commit_len), DEPTH));
  assign avail  = pos < len;
  assign last   = (pos + 1'b1) == len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      len <= '0;
    end else if (commit) begin
      pos <= '0;
      len <= len_cl;
    end else if (rd_en && avail) begin
      if (last) begin
        pos <= '0;
        len <= '0;
      end else begin
        pos <= pos + 1'b1;
      end
    end else if (pos_clr) begin
      pos <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = avail ? mem[pos[IDX_W-1:0]] : 8'hFF;

  // R5: the read position stays inside the committed response
  a_r5_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (len != '0) |-> (pos < len));
  a_r5_empty_pos_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (len == '0) |-> (pos == '0));

endmodule

// File: rtl/bt_host_regs.sv
module bt_host_regs
  import bt_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = $clog2(DEPTH + 1) + 1,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [1:0]       host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic             irq_glb_en,
  output logic             irq_out,
  output logic             req_ready,
  output logic [LEN_W-1:0] req_len,
  input  logic [IDX_W-1:0] req_rd_idx,
  output logic [7:0]       req_rd_data,
  input  logic             rsp_wr_en,
  input  logic [IDX_W-1:0] rsp_wr_idx,
  input  logic [7:0]       rsp_wr_data,
  input  logic             rsp_commit,
  input  logic [LEN_W-1:0] rsp_commit_len,
  input  logic             sms_set,
  input  logic             sms_clr,
  input  logic             sms_irq
);

  // decoded host accesses, named for the checks
  logic ctl_wr, dat_wr, msk_wr, dat_rd;
  logic req_go, wptr_clr, rptr_clr;
  bt_flags_t flags;
  logic [7:0] rsp_byte;

  assign ctl_wr   = host_wr && host_addr == A_CTL;
  assign dat_wr   = host_wr && host_addr == A_DAT;
  assign msk_wr   = host_wr && host_addr == A_MSK;
  assign dat_rd   = host_rd && host_addr == A_DAT;
  assign req_go   = ctl_wr && host_wdata[CB_REQ_GO];
  assign wptr_clr = ctl_wr && host_wdata[CB_WPTR_CLR];
  assign rptr_clr = ctl_wr && host_wdata[CB_RPTR_CLR];

  bt_flag_ctl u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .msk_wr     (msk_wr),
    .wdata      (host_wdata),
    .rsp_commit (rsp_commit),
    .sms_set    (sms_set),
    .sms_clr    (sms_clr),
    .sms_irq    (sms_irq),
    .flags      (flags)
  );

  bt_req_buf #(.DEPTH(DEPTH), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (dat_wr),
    .clr     (wptr_clr),
    .wdata   (host_wdata),
    .len     (req_len),
    .rd_idx  (req_rd_idx),
    .rd_data (req_rd_data)
  );

  bt_rsp_buf #(.DEPTH(DEPTH), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (rsp_wr_en),
    .wr_idx     (rsp_wr_idx),
    .wr_data    (rsp_wr_data),
    .commit     (rsp_commit),
    .commit_len (rsp_commit_len),
    .rd_en      (dat_rd),
    .pos_clr    (rptr_clr),
    .rd_data    (rsp_byte)
  );

  always_comb begin
    unique case (host_addr)
      A_CTL:   host_rdata = ctl_byte(flags);
      A_DAT:   host_rdata = rsp_byte;
      A_MSK:   host_rdata = msk_byte(flags);
      default: host_rdata = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_ready <= 1'b0;
    else        req_ready <= req_go;
  end

  assign irq_out = flags.pend & irq_glb_en;

  // R3: doorbell gives busy and a one-cycle pulse
  a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_go |=> req_ready);
  a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !$past(req_ready));
  a_r3_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    (req_go && !rsp_commit) |=> flags.ctl_bsy);

  // R11: interrupt output never rises without the global gate
  a_r11_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> irq_glb_en);

endmodule

// File: tb/sim_bt_host_regs.sv
module sim_bt_host_regs;

  localparam int CLK_P = 10;
  localparam int DEPTH = 8;
  localparam int LEN_W = $clog2(DEPTH + 1) + 1;
  localparam int IDX_W = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0]       host_addr = 2'd0;
  logic [7:0]       host_wdata = 8'h00;
  logic [7:0]       host_rdata;
  logic             irq_glb_en = 1'b1;
  logic             irq_out, req_ready;
  logic [LEN_W-1:0] req_len;
  logic [IDX_W-1:0] req_rd_idx = '0;
  logic [7:0]       req_rd_data;
  logic             rsp_wr_en = 1'b0;
  logic [IDX_W-1:0] rsp_wr_idx = '0;
  logic [7:0]       rsp_wr_data = 8'h00;
  logic             rsp_commit = 1'b0;
  logic [LEN_W-1:0] rsp_commit_len = '0;
  logic             sms_set = 1'b0, sms_clr = 1'b0, sms_irq = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_P / 2) clk = ~clk;

  bt_host_regs #(.DEPTH(DEPTH), .LEN_W(LEN_W), .IDX_W(IDX_W)) u0 (.*);

  task automatic chk(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // monitor: compares every read strobe against the queued expectation
  always @(negedge clk) begin
    if (host_rd) begin
      if (exp_q.size() == 0) chk("read without expectation", 1, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, int'(host_rdata), int'(e));
      end
    end
  end

  task automatic hwr(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic hrd(logic [1:0] a, logic [7:0] e, string tag);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(tag);
    host_rd = 1'b1; host_addr = a;
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  task automatic rsp_put(int i, logic [7:0] d);
    @(posedge clk); #1;
    rsp_wr_en = 1'b1; rsp_wr_idx = IDX_W'(i); rsp_wr_data = d;
    @(posedge clk); #1;
    rsp_wr_en = 1'b0;
  endtask

  task automatic rsp_go(int n);
    @(posedge clk); #1;
    rsp_commit = 1'b1; rsp_commit_len = LEN_W'(n);
    @(posedge clk); #1;
    rsp_commit = 1'b0;
  endtask

  task automatic sms(logic set, logic irq);
    @(posedge clk); #1;
    sms_set = set; sms_clr = ~set; sms_irq = irq;
    @(posedge clk); #1;
    sms_set = 1'b0; sms_clr = 1'b0; sms_irq = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog got=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R12 reset state, R1 decode, R5 empty read
    @(negedge clk);
    chk("R12 irq_out after reset", irq_out, 0);
    chk("R12 req_len after reset", int'(req_len), 0);
    hrd(2'd0, 8'h00, "R12 control after reset");
    hrd(2'd2, 8'h00, "R12 mask after reset");
    hrd(2'd1, 8'hFF, "R5 empty data read");
    hrd(2'd3, 8'hFF, "R1 unused offset");

    // R4 request fill, R3 doorbell
    for (int i = 0; i < 4; i++) hwr(2'd1, 8'h30 + 8'(i));
    @(negedge clk);
    chk("R4 req_len after 4 writes", int'(req_len), 4);
    req_rd_idx = 3'd2; #1;
    chk("R4 stored byte 2", int'(req_rd_data), 8'h32);
    hwr(2'd0, 8'h04);
    @(negedge clk);
    chk("R3 req_ready pulse", req_ready, 1);
    @(negedge clk);
    chk("R3 req_ready drops", req_ready, 0);
    hrd(2'd0, 8'h80, "R3 controller busy set");

    // R2 host busy toggle
    hwr(2'd0, 8'h40);
    hrd(2'd0, 8'hC0, "R2 host busy toggled on");
    hwr(2'd0, 8'h40);
    hrd(2'd0, 8'h80, "R2 host busy toggled off");

    // enable without attention
    hwr(2'd2, 8'h01);
    hrd(2'd2, 8'h01, "R7 enable without attention");
    @(negedge clk);
    chk("R7 no irq without attention", irq_out, 0);

    // R10 commit
    rsp_put(0, 8'hA1); rsp_put(1, 8'hB2); rsp_put(2, 8'hC3);
    rsp_go(3);
    @(negedge clk);
    chk("R10 irq after commit", irq_out, 1);
    hrd(2'd0, 8'h08, "R10 control after commit");
    hrd(2'd2, 8'h03, "R10 mask after commit");

    // R5 drain
    hrd(2'd1, 8'hA1, "R5 byte 0");
    hrd(2'd1, 8'hB2, "R5 byte 1");
    hrd(2'd1, 8'hC3, "R5 byte 2");
    hrd(2'd1, 8'hFF, "R5 after last byte");

    // R8 acknowledge pending
    hwr(2'd2, 8'h03);
    @(negedge clk);
    chk("R8 irq after ack", irq_out, 0);
    hrd(2'd2, 8'h01, "R8 mask after ack");
    hwr(2'd0, 8'h08);
    hrd(2'd0, 8'h00, "R2 clear rsp attention");

    // R9 system attention
    sms(1'b1, 1'b1);
    @(negedge clk);
    chk("R9 irq on sys attention", irq_out, 1);
    hrd(2'd0, 8'h10, "R9 control sys attention");
    hrd(2'd2, 8'h03, "R9 mask pending");
    sms(1'b0, 1'b0);
    hrd(2'd2, 8'h01, "R9 clear drops pending");
    sms(1'b1, 1'b0);
    hrd(2'd2, 8'h01, "R9 set without irq request");
    hwr(2'd0, 8'h10);
    hrd(2'd0, 8'h00, "R2 clear sys attention");
    hrd(2'd2, 8'h01, "R2 sys clear leaves mask");

    // R7 enable transitions with attention standing
    hwr(2'd2, 8'h00);
    rsp_go(1);
    hrd(2'd2, 8'h00, "R7 commit while disabled");
    hwr(2'd2, 8'h01);
    hrd(2'd2, 8'h03, "R7 enable with attention");
    hwr(2'd2, 8'h00);
    @(negedge clk);
    chk("R7 disable lowers irq", irq_out, 0);
    hrd(2'd2, 8'h00, "R7 disable clears pending");

    // R11 global gate
    irq_glb_en = 1'b0;
    hwr(2'd2, 8'h01);
    @(negedge clk);
    chk("R11 gated irq", irq_out, 0);
    hrd(2'd2, 8'h03, "R11 pending while gated");
    irq_glb_en = 1'b1;
    @(negedge clk);
    chk("R11 ungated irq", irq_out, 1);
    hwr(2'd2, 8'h02);
    hwr(2'd0, 8'h08);

    // R6 clear write pointer, R4 overrun
    hwr(2'd0, 8'h01);
    @(negedge clk);
    chk("R6 write pointer cleared", int'(req_len), 0);
    for (int i = 0; i < DEPTH + 2; i++) hwr(2'd1, 8'h50 + 8'(i));
    @(negedge clk);
    chk("R4 overrun count", int'(req_len), DEPTH + 2);
    req_rd_idx = 3'd7; #1;
    chk("R4 last slot kept", int'(req_rd_data), 8'h57);
    req_rd_idx = 3'd0; #1;
    chk("R4 first slot kept", int'(req_rd_data), 8'h50);

    // R6 clear read pointer
    rsp_put(0, 8'h11); rsp_put(1, 8'h22);
    rsp_go(2);
    hrd(2'd1, 8'h11, "R6 first read");
    hwr(2'd0, 8'h02);
    hrd(2'd1, 8'h11, "R6 reread after pointer clear");
    hrd(2'd1, 8'h22, "R6 second byte");
    hrd(2'd1, 8'hFF, "R5 empty again");

    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule